// File: doc/BRIEF.md
# Serial SAR ADC Host Controller

This block sits on the host side of a self-calibrating successive-approximation converter that has a serial output, and drives that converter through its digital pins alone. After reset it treats the converter as uncalibrated and accepts no conversions. A calibration request raises the calibrate line for a fixed number of cycles. While the converter reports busy, the block keeps the conversion clock running freely. It waits for the busy flag to drop and raises an error flag if that takes far too long.

Once calibrated, each conversion has three phases. The sample line is held high for a programmed acquisition count. After the sample line drops, a programmed gap passes before a gated burst of exactly 17 conversion-clock pulses is issued. The half-period of the conversion clock is also programmable. Serial bits are captured at the end of the high phase of pulses 2 through 17, most significant bit first. They are presented as a signed 16-bit word with a one-cycle valid strobe. In continuous mode the next acquisition begins together with the rising edge of the 17th pulse. A calibration request aborts any conversion in progress.

Top module: `sar_adc_host`

## Requirements
- R1: While reset is held, and afterwards, sample_o, cclk_o, cal_o, result_valid_o and cal_err_o are 0. Until a calibration has completed without error, start_i and cont_i never raise sample_o.
- R2: A calibration request outside calibration drives cal_o high for exactly CAL_PULSE cycles. sample_o stays 0 for the whole calibration.
- R3: After cal_o falls, cclk_o runs freely with high and low phases of half_len_i cycles each, the first rise coming one cycle after cal_o falls. Calibration completes when busy_i is sampled low, and conversions are accepted from then on.
- R4: If busy_i is still high CAL_TIMEOUT cycles after cal_o falls, cal_err_o goes to 1 and the block returns to the uncalibrated state. cal_err_o stays 1 until the next calibration request, which clears it.
- R5: When calibrated, idle, with busy_i low and start_i or cont_i high, sample_o goes high for exactly acq_len_i cycles (a value of 0 counts as 1).
- R6: The first rise of cclk_o comes exactly gap_len_i cycles after sample_o falls (0 counts as 1). cclk_o never rises while sample_o has been high for more than one cycle.
- R7: Each conversion issues exactly 17 cclk_o pulses, each with high and low phases of half_len_i cycles (0 counts as 1). No further pulse follows.
- R8: The value on sdata_i in the last high cycle of pulse k (k = 2..17) becomes bit 17-k of result_o, so the first bit captured is the most significant. result_valid_o is high for exactly one cycle, the first low cycle after pulse 17, and result_o holds the captured two's-complement word from then until the next strobe.
- R9: With cont_i high at the 17th pulse, sample_o rises in the same cycle as cclk_o's 17th rise. It stays high for acq_len_i cycles counted from that rise when acq_len_i exceeds twice half_len_i, and then the next gap and burst follow.
- R10: A calibration request during a conversion drops cclk_o and sample_o and raises cal_o in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one conversion (level, taken when idle) |
| cont_i | input | 1 | Continuous conversion request |
| cal_req_i | input | 1 | Calibration request |
| busy_i | input | 1 | Converter busy flag |
| sdata_i | input | 1 | Converter serial data |
| acq_len_i | input | CNT_W | Acquisition length in system cycles |
| gap_len_i | input | CNT_W | Delay from sample fall to first clock rise |
| half_len_i | input | CNT_W | Conversion-clock half-period in system cycles |
| sample_o | output | 1 | Sample line to converter |
| cclk_o | output | 1 | Gated conversion clock |
| cal_o | output | 1 | Calibrate line to converter |
| result_o | output | DATA_W | Signed conversion result |
| result_valid_o | output | 1 | One-cycle strobe for a new result |
| cal_err_o | output | 1 | Calibration timed out |

## Verification
The hardest situation to reach is the overlap in continuous mode. There the next acquisition starts on the 17th clock rise, while that pulse's data bit is still to be captured. The bench gets there with a behavioural converter model that shifts a different word for every conversion, and it checks that the acquisition count spans the end of the burst. The calibration timeout needs busy to stay high on purpose, so the model has a stuck flag. An abort is raised after the third pulse of a running burst, and the bench then checks that a fresh calibration restores normal conversions.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;

    typedef enum logic [2:0] {
        H_UNCAL,
        H_CAL,
        H_READY,
        H_ACQ,
        H_GAP,
        H_CONV
    } host_state_e;

    typedef enum logic [1:0] {
        C_IDLE,
        C_PULSE,
        C_WAIT
    } cal_state_e;

endpackage

// File: rtl/sar_cal_seq.sv
module sar_cal_seq
    import sar_host_pkg::*;
#(
    parameter int CAL_PULSE   = 4,
    parameter int CAL_TIMEOUT = 120000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic busy_i,
    output logic cal_o,
    output logic wait_o,
    output logic done_o,
    output logic fail_o,
    output logic err_o
);
    localparam int LIMIT = (CAL_TIMEOUT > CAL_PULSE) ? CAL_TIMEOUT : CAL_PULSE;
    localparam int TW    = $clog2(LIMIT + 1);

    typedef struct packed {
        cal_state_e      st;
        logic [TW-1:0]   cnt;
        logic            cal;
        logic            err;
    } cal_regs_t;

    cal_regs_t q, d;

    always_comb begin
        d      = q;
        done_o = 1'b0;
        fail_o = 1'b0;
        if (go_i) begin
            d.st  = C_PULSE;
            d.cnt = '0;
            d.cal = 1'b1;
            d.err = 1'b0;
        end else begin
            case (q.st)
                C_PULSE: begin
                    if (q.cnt == TW'(CAL_PULSE - 1)) begin
                        d.st  = C_WAIT;
                        d.cnt = '0;
                        d.cal = 1'b0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                C_WAIT: begin
                    if (!busy_i) begin
                        d.st   = C_IDLE;
                        done_o = 1'b1;
                    end else if (q.cnt == TW'(CAL_TIMEOUT - 1)) begin
                        d.st   = C_IDLE;
                        d.err  = 1'b1;
                        fail_o = 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d.st = C_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st  <= C_IDLE;
            q.cnt <= '0;
            q.cal <= 1'b0;
            q.err <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cal_o  = q.cal;
    assign wait_o = (q.st == C_WAIT);
    assign err_o  = q.err;

    // R4: an error flag survives until a new request
    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !go_i) |=> err_o);

    // R2: calibrate line is released before waiting on busy
    p_no_cal_in_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wait_o |-> !cal_o);

endmodule

// File: rtl/sar_clk_burst.sv
module sar_clk_burst #(
    parameter int CNT_W  = 16,
    parameter int PULSES = 17
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      go_i,
    input  logic                      free_i,
    input  logic                      abort_i,
    input  logic [CNT_W-1:0]          half_len_i,
    output logic                      cclk_o,
    output logic                      active_o,
    output logic                      fall_o,
    output logic                      last_rise_o,
    output logic                      done_o,
    output logic [$clog2(PULSES)-1:0] idx_o
);
    localparam int IDX_W = $clog2(PULSES);

    typedef struct packed {
        logic             active;
        logic             high;
        logic             free;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
    } burst_regs_t;

    burst_regs_t      q, d;
    logic [CNT_W-1:0] half_m1;
    logic             phase_end;

    assign half_m1   = (half_len_i == '0) ? '0 : half_len_i - 1'b1;
    assign phase_end = q.active && (q.cnt >= half_m1);

    always_comb begin
        d = q;
        if (abort_i) begin
            d.active = 1'b0;
            d.high   = 1'b0;
            d.free   = 1'b0;
            d.cnt    = '0;
            d.idx    = '0;
        end else if (!q.active) begin
            if (go_i || free_i) begin
                d.active = 1'b1;
                d.high   = 1'b1;
                d.free   = free_i;
                d.cnt    = '0;
                d.idx    = '0;
            end
        end else if (phase_end) begin
            d.cnt = '0;
            if (q.high) begin
                d.high = 1'b0;
            end else if (q.free) begin
                if (free_i) d.high   = 1'b1;
                else        d.active = 1'b0;
            end else if (q.idx == IDX_W'(PULSES - 1)) begin
                d.active = 1'b0;
            end else begin
                d.idx  = q.idx + 1'b1;
                d.high = 1'b1;
            end
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.active <= 1'b0;
            q.high   <= 1'b0;
            q.free   <= 1'b0;
            q.cnt    <= '0;
            q.idx    <= '0;
        end else begin
            q <= d;
        end
    end

    assign cclk_o      = q.high;
    assign active_o    = q.active;
    assign idx_o       = q.idx;
    assign fall_o      = phase_end && !q.free && q.high;
    assign last_rise_o = phase_end && !q.free && !q.high && (q.idx == IDX_W'(PULSES - 2));
    assign done_o      = phase_end && !q.free && !q.high && (q.idx == IDX_W'(PULSES - 1));

    // R7: a counted burst only stops after its final pulse
    p_burst_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.active && $past(q.active) && !$past(q.free) && !$past(abort_i))
        |-> ($past(q.idx) == IDX_W'(PULSES - 1)));

    // R7: clock stays low whenever no burst is running
    p_clk_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> !cclk_o);

endmodule

// File: rtl/sar_shift_rx.sv
module sar_shift_rx #(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift_i,
    input  logic                     last_i,
    input  logic                     sdata_i,
    output logic signed [DATA_W-1:0] data_o,
    output logic                     valid_o
);
    typedef struct packed {
        logic [DATA_W-2:0] sh;
        logic [DATA_W-1:0] data;
        logic              valid;
    } rx_regs_t;

    rx_regs_t q, d;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        if (shift_i) begin
            d.sh = {q.sh[DATA_W-3:0], sdata_i};
            if (last_i) begin
                d.data  = {q.sh, sdata_i};
                d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.sh    <= '0;
            q.data  <= '0;
            q.valid <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign data_o  = q.data;
    assign valid_o = q.valid;

    // R8: the strobe is a single cycle wide
    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

endmodule

// File: rtl/sar_adc_host.sv
module sar_adc_host
    import sar_host_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 16,
    parameter int CAL_PULSE   = 4,
    parameter int CAL_TIMEOUT = 120000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     cont_i,
    input  logic                     cal_req_i,
    input  logic                     busy_i,
    input  logic                     sdata_i,
    input  logic [CNT_W-1:0]         acq_len_i,
    input  logic [CNT_W-1:0]         gap_len_i,
    input  logic [CNT_W-1:0]         half_len_i,
    output logic                     sample_o,
    output logic                     cclk_o,
    output logic                     cal_o,
    output logic signed [DATA_W-1:0] result_o,
    output logic                     result_valid_o,
    output logic                     cal_err_o
);
    localparam int PULSES = DATA_W + 1;
    localparam int IDX_W  = $clog2(PULSES);

    typedef struct packed {
        host_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic             sample;
    } host_regs_t;

    host_regs_t       q, d;
    logic             cal_go, cal_wait, cal_done, cal_fail;
    logic             burst_go, abort;
    logic             b_active, b_fall, b_last_rise, b_done;
    logic [IDX_W-1:0] b_idx;
    logic [CNT_W-1:0] acq_m1, gap_m1;

    assign acq_m1 = (acq_len_i == '0) ? '0 : acq_len_i - 1'b1;
    assign gap_m1 = (gap_len_i == '0) ? '0 : gap_len_i - 1'b1;

    always_comb begin
        d        = q;
        cal_go   = 1'b0;
        abort    = 1'b0;
        burst_go = 1'b0;
        if (cal_req_i && q.st != H_CAL) begin
            cal_go   = 1'b1;
            abort    = 1'b1;
            d.st     = H_CAL;
            d.sample = 1'b0;
            d.cnt    = '0;
        end else begin
            case (q.st)
                H_UNCAL: d = q;
                H_CAL: begin
                    if (cal_done)      d.st = H_READY;
                    else if (cal_fail) d.st = H_UNCAL;
                end
                H_READY: begin
                    if ((start_i || cont_i) && !busy_i && !b_active) begin
                        d.st     = H_ACQ;
                        d.sample = 1'b1;
                        d.cnt    = '0;
                    end
                end
                H_ACQ: begin
                    if (q.cnt >= acq_m1) begin
                        d.st     = H_GAP;
                        d.sample = 1'b0;
                        d.cnt    = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                H_GAP: begin
                    if (q.cnt >= gap_m1) begin
                        burst_go = 1'b1;
                        d.st     = H_CONV;
                        d.cnt    = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                H_CONV: begin
                    if (b_last_rise && cont_i) begin
                        d.sample = 1'b1;
                        d.cnt    = '0;
                    end else if (q.sample && q.cnt < acq_m1) begin
                        d.cnt = q.cnt + 1'b1;
                    end
                    if (b_done) d.st = q.sample ? H_ACQ : H_READY;
                end
                default: d.st = H_UNCAL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st     <= H_UNCAL;
            q.cnt    <= '0;
            q.sample <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sample_o = q.sample;

    sar_cal_seq #(
        .CAL_PULSE  (CAL_PULSE),
        .CAL_TIMEOUT(CAL_TIMEOUT)
    ) u_cal (
        .clk   (clk),
        .rst_n (rst_n),
        .go_i  (cal_go),
        .busy_i(busy_i),
        .cal_o (cal_o),
        .wait_o(cal_wait),
        .done_o(cal_done),
        .fail_o(cal_fail),
        .err_o (cal_err_o)
    );

    sar_clk_burst #(
        .CNT_W (CNT_W),
        .PULSES(PULSES)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (burst_go),
        .free_i     (cal_wait),
        .abort_i    (abort),
        .half_len_i (half_len_i),
        .cclk_o     (cclk_o),
        .active_o   (b_active),
        .fall_o     (b_fall),
        .last_rise_o(b_last_rise),
        .done_o     (b_done),
        .idx_o      (b_idx)
    );

    sar_shift_rx #(
        .DATA_W(DATA_W)
    ) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .shift_i(b_fall && (b_idx != '0)),
        .last_i (b_idx == IDX_W'(PULSES - 1)),
        .sdata_i(sdata_i),
        .data_o (result_o),
        .valid_o(result_valid_o)
    );

    // R1: no sampling before a good calibration
    p_uncal_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == H_UNCAL) |-> !sample_o);

    // R2: sample line low through calibration
    p_cal_sample_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == H_CAL) |-> !sample_o);

    // R6: no clock edge during an established acquisition
    p_no_clk_in_acq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_o && $past(sample_o)) |-> !$rose(cclk_o));

    // R10: calibration request aborts a running conversion
    p_cal_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_req_i && q.st != H_CAL) |=> (cal_o && !cclk_o && !sample_o));

endmodule

// File: tb/tb_sar_adc_host.sv
`timescale 1ns/1ps
module tb_sar_adc_host;
    localparam int DATA_W   = 16;
    localparam int CNT_W    = 16;
    localparam int CPULSE   = 4;
    localparam int CTIMEOUT = 600;
    localparam int CAL_CLKS = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, cont_i = 1'b0, cal_req_i = 1'b0;
    logic busy_m = 1'b0, sdata_m = 1'b0;
    logic [CNT_W-1:0] acq_len = 16'd12, gap_len = 16'd3, half_len = 16'd2;
    logic sample_o, cclk_o, cal_o, result_valid_o, cal_err_o;
    logic signed [DATA_W-1:0] result_o;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    sar_adc_host #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .CAL_PULSE(CPULSE), .CAL_TIMEOUT(CTIMEOUT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
        .cal_req_i(cal_req_i), .busy_i(busy_m), .sdata_i(sdata_m),
        .acq_len_i(acq_len), .gap_len_i(gap_len), .half_len_i(half_len),
        .sample_o(sample_o), .cclk_o(cclk_o), .cal_o(cal_o),
        .result_o(result_o), .result_valid_o(result_valid_o), .cal_err_o(cal_err_o)
    );

    // behavioural converter model
    logic [15:0] mw [0:15];
    logic [15:0] word_m = 16'h0;
    int conv_idx = 0;
    int pulse_n = 0;
    int cal_cnt = 0;
    bit in_cal = 1'b0;
    bit stuck = 1'b0;

    always @(posedge cal_o) begin
        busy_m  = 1'b1;
        in_cal  = 1'b1;
        cal_cnt = 0;
    end

    always @(negedge sample_o) begin
        if (!in_cal && rst_n) begin
            busy_m   = 1'b1;
            pulse_n  = 0;
            word_m   = mw[conv_idx];
            conv_idx = conv_idx + 1;
        end
    end

    always @(posedge cclk_o) begin
        if (in_cal) begin
            if (!cal_o) begin
                cal_cnt = cal_cnt + 1;
                if (cal_cnt == CAL_CLKS && !stuck) begin
                    busy_m = 1'b0;
                    in_cal = 1'b0;
                end
            end
        end else begin
            pulse_n = pulse_n + 1;
            if (pulse_n >= 2 && pulse_n <= 17) sdata_m = word_m[17 - pulse_n];
            if (pulse_n == 17) busy_m = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset;
        int hi;
        chk(!sample_o && !cclk_o && !cal_o && !result_valid_o && !cal_err_o,
            "R1 outputs in reset", int'({sample_o, cclk_o, cal_o, result_valid_o, cal_err_o}), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(!sample_o && !cclk_o && !cal_o && !result_valid_o && !cal_err_o,
            "R1 outputs after reset", int'({sample_o, cclk_o, cal_o, result_valid_o, cal_err_o}), 0);
        hi = 0;
        start_i = 1'b1;
        repeat (20) begin @(negedge clk); if (sample_o) hi++; end
        start_i = 1'b0;
        chk(hi == 0, "R1 start ignored when uncalibrated", hi, 0);
    endtask

    task automatic t_cal;
        int n;
        int b;
        @(negedge clk); cal_req_i = 1'b1;
        @(negedge clk); cal_req_i = 1'b0;
        n = 0;
        while (cal_o) begin
            if (sample_o) chk(0, "R2 sample low in calibration", 1, 0);
            n++; @(negedge clk);
        end
        chk(n == CPULSE, "R2 cal pulse length", n, CPULSE);
        b = 0;
        while (busy_m) begin
            if (sample_o) chk(0, "R2 sample low while waiting", 1, 0);
            b++; @(negedge clk);
        end
        chk(b == 1 + (CAL_CLKS - 1) * 2 * int'(half_len), "R3 free clock timing to busy fall",
            b, 1 + (CAL_CLKS - 1) * 2 * int'(half_len));
        chk(cal_err_o == 1'b0, "R3 no error after good calibration", int'(cal_err_o), 0);
    endtask

    // from first negedge with sample low: gap, pulses, result
    task automatic run_burst(input logic [15:0] w, input bit overlap);
        int g;
        int h;
        int l;
        int s;
        g = 0;
        while (!cclk_o) begin g++; @(negedge clk); end
        chk(g == int'(gap_len), "R6 gap before first clock", g, int'(gap_len));
        for (int p = 1; p <= 17; p++) begin
            h = 0;
            while (cclk_o) begin
                if (p == 17 && h == 0 && overlap)
                    chk(sample_o == 1'b1, "R9 sample rises with 17th pulse", int'(sample_o), 1);
                if (p < 17 && sample_o) chk(0, "R6 no sampling during burst", 1, 0);
                h++; @(negedge clk);
            end
            chk(h == int'(half_len), "R7 high phase width", h, int'(half_len));
            if (p == 17) begin
                chk(result_valid_o == 1'b1, "R8 valid after 17th fall", int'(result_valid_o), 1);
                chk(result_o == w, "R8 result word", int'(result_o), int'(w));
                if (overlap) begin
                    s = h;
                    while (sample_o) begin s++; @(negedge clk); end
                    chk(s == int'(acq_len), "R9 overlapped acquisition length", s, int'(acq_len));
                end else begin
                    @(negedge clk);
                    chk(result_valid_o == 1'b0, "R8 valid single cycle", int'(result_valid_o), 0);
                    s = 0;
                    repeat (4 * int'(half_len) + 4) begin @(negedge clk); if (cclk_o) s++; end
                    chk(s == 0, "R7 no 18th pulse", s, 0);
                    chk(result_o == w, "R8 result held", int'(result_o), int'(w));
                end
            end else begin
                l = 0;
                while (!cclk_o) begin l++; @(negedge clk); end
                chk(l == int'(half_len), "R7 low phase width", l, int'(half_len));
            end
        end
    endtask

    task automatic t_single(input logic [15:0] w, input int a, input int g, input int hl);
        int n;
        acq_len = CNT_W'(a); gap_len = CNT_W'(g); half_len = CNT_W'(hl);
        mw[conv_idx] = w;
        @(negedge clk); start_i = 1'b1;
        while (!sample_o) @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (sample_o) begin n++; @(negedge clk); end
        chk(n == a, "R5 acquisition length", n, a);
        run_burst(w, 1'b0);
    endtask

    task automatic t_cont(input logic [15:0] w0, input logic [15:0] w1);
        int n;
        acq_len = 16'd10; gap_len = 16'd2; half_len = 16'd2;
        mw[conv_idx] = w0; mw[conv_idx + 1] = w1;
        @(negedge clk); cont_i = 1'b1;
        while (!sample_o) @(negedge clk);
        n = 0;
        while (sample_o) begin n++; @(negedge clk); end
        chk(n == 10, "R5 first continuous acquisition", n, 10);
        run_burst(w0, 1'b1);
        cont_i = 1'b0;
        run_burst(w1, 1'b0);
    endtask

    task automatic t_abort;
        int r;
        acq_len = 16'd6; gap_len = 16'd2; half_len = 16'd2;
        mw[conv_idx] = 16'h5555;
        @(negedge clk); start_i = 1'b1;
        while (!sample_o) @(negedge clk);
        start_i = 1'b0;
        r = 0;
        while (r < 3) begin
            @(negedge clk);
            if (cclk_o) begin r++; while (cclk_o) @(negedge clk); end
        end
        while (!cclk_o) @(negedge clk);
        cal_req_i = 1'b1;
        @(negedge clk); cal_req_i = 1'b0;
        chk(cal_o && !cclk_o && !sample_o, "R10 abort on calibration request",
            int'({cal_o, cclk_o, sample_o}), 4);
        while (busy_m) @(negedge clk);
        chk(cal_err_o == 1'b0, "R10 recalibration clean", int'(cal_err_o), 0);
        t_single(16'h0001, 8, 2, 1);
    endtask

    task automatic t_timeout;
        int hi;
        stuck = 1'b1;
        @(negedge clk); cal_req_i = 1'b1;
        @(negedge clk); cal_req_i = 1'b0;
        while (cal_o) @(negedge clk);
        repeat (CTIMEOUT - 6) @(negedge clk);
        chk(cal_err_o == 1'b0, "R4 no error before timeout", int'(cal_err_o), 0);
        repeat (10) @(negedge clk);
        chk(cal_err_o == 1'b1, "R4 error after timeout", int'(cal_err_o), 1);
        hi = 0;
        start_i = 1'b1;
        repeat (30) begin @(negedge clk); if (sample_o) hi++; end
        start_i = 1'b0;
        chk(hi == 0, "R4 uncalibrated after timeout", hi, 0);
        chk(cal_err_o == 1'b1, "R4 error held", int'(cal_err_o), 1);
        stuck = 1'b0;
        @(negedge clk); cal_req_i = 1'b1;
        @(negedge clk); cal_req_i = 1'b0;
        chk(cal_err_o == 1'b0, "R4 error cleared by request", int'(cal_err_o), 0);
        while (busy_m) @(negedge clk);
        t_single(16'h7FFF, 5, 1, 1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mw[i] = 16'h0;
        repeat (3) @(negedge clk);
        t_reset();
        t_cal();
        t_single(16'hA5C3, 12, 3, 2);
        t_single(16'h8000, 20, 5, 3);
        t_single(16'h1234, 1, 1, 1);
        t_cont(16'h0F0F, 16'hFFFF);
        t_abort();
        t_timeout();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule